// File: doc/BRIEF.md
# Two-Wire Debug Link Host Engine

This block is the host end of a two-wire serial debug link. It generates the link clock from the system clock and runs one whole transaction at a time over a half-duplex data line. The data line appears at the ports as three separate signals: a driven value, an output enable, and the value sampled from the pad. A command is a one-cycle start strobe that carries a port-select bit (access port or debug port), a read/write flag, a two-bit register address and a 32-bit write word. The engine builds and sends the request header and releases the line for the target. It then collects the three-bit acknowledge and, when that acknowledge is OK, either sends the write word or captures the read word, each followed by its parity bit.

The host changes the data line only while the link clock is low. It samples target-driven bits at the end of each bit period, just before the clock falls, because the target updates its bits on the rising edge. Every bit period takes two half-periods of `HALF_DIV` system clocks each. When the target returns anything other than OK, the payload is dropped: the host takes one turnaround cycle to recover the line and reports only the acknowledge. At the end of each transaction the engine gives a one-cycle done strobe and holds its results until the next command.

Top module: `sdbg_host`

## Requirements
- R1: After reset, and between transactions, `dbg_clk` is low, `dbg_dout` is low, `dbg_doe` is high and `rsp_done` is low.
- R2: While a transaction runs, each `dbg_clk` period is `2*HALF_DIV` system clocks. `dbg_dout` and `dbg_doe` change only while `dbg_clk` is low.
- R3: The first 8 link bits are driven by the host with the enable set, in this order: 1, port select (1 = access port), read flag (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, header parity, 0, 1.
- R4: Header bit 5 is 1 exactly when port select, read flag and the two address bits hold an odd count of ones.
- R5: Link bit 8 is a turnaround: the enable is low and the value on `dbg_din` in that bit is not captured.
- R6: Link bits 9 to 11 are the target acknowledge, received least significant bit first with the enable low. `rsp_ack` reports it with OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100.
- R7: For a write with OK, bit 12 is a turnaround with the enable low. Bits 13 to 44 carry `cmd_wdata` least significant bit first with the enable high, and bit 45 carries the odd-count parity of the word. The transaction has 46 clock periods.
- R8: For a read with OK, bits 12 to 43 are captured least significant bit first into `rsp_rdata`, bit 44 is the target parity, and bit 45 is a turnaround. The enable stays low from bit 12 to bit 45, and the transaction has 46 clock periods.
- R9: On a read, `rsp_perr` is 1 exactly when the received parity bit differs from the odd-count parity of the received word. `rsp_rdata` is returned in either case.
- R10: When the acknowledge is not 3'b001, bit 12 is the last period and is a turnaround. The transaction has 13 clock periods, `rsp_rdata` is zero and `rsp_perr` is 0.
- R11: `rsp_done` is high for exactly one system cycle after the last bit period. A start strobe while a transaction runs is ignored, and the results hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command strobe, taken only while idle |
| cmd_ap | input | 1 | 1 selects an access port, 0 the debug port |
| cmd_rd | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write word |
| rsp_ack | output | 3 | Acknowledge received from the target |
| rsp_rdata | output | 32 | Captured read word |
| rsp_perr | output | 1 | Read parity mismatch |
| rsp_done | output | 1 | One-cycle end-of-transaction strobe |
| dbg_clk | output | 1 | Link clock |
| dbg_dout | output | 1 | Value the host drives onto the data line |
| dbg_doe | output | 1 | Host output enable for the data line |
| dbg_din | input | 1 | Value sampled from the data line |

## Verification
The bench runs all sixteen combinations of port select, read flag and address. This shows that each header field lands in its own bit slot and that parity follows the field count. Because reads and writes are mixed in that sweep, it also shows that the turnaround sits in the right place for each direction. Data words include walking ones, all ones, all zeros and mixed patterns, so bit-order reversal and parity polarity can be told apart. Acknowledge values WAIT, FAULT, 3'b111 and 3'b000 check the short path. Reads with the parity bit flipped separate a parity error from data loss. The target model drives ones during every turnaround, so any sample taken in a turnaround shows up as a wrong acknowledge or word. A start pulse sent in the middle of a transaction checks that commands are ignored while busy.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

  localparam int HDR_BITS = 8;
  localparam int ACK_BITS = 3;
  localparam int DATA_BITS = 32;
  localparam int PAY_BITS = DATA_BITS + 1;
  localparam int CNT_W = $clog2(PAY_BITS + 1);

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_H,
    ST_ACK,
    ST_TRN_W,
    ST_WDAT,
    ST_RDAT,
    ST_TRN_E
  } seq_state_t;

  // odd-count parity of the four header fields
  function automatic logic hdr_parity(input logic ap, input logic rd,
                                      input logic [1:0] addr);
    return ap ^ rd ^ addr[0] ^ addr[1];
  endfunction

  // odd-count parity of a data word
  function automatic logic word_parity(input logic [DATA_BITS-1:0] w);
    return ^w;
  endfunction

  // header laid out in wire order, bit 0 leaves first
  function automatic logic [HDR_BITS-1:0] build_hdr(input logic ap, input logic rd,
                                                   input logic [1:0] addr);
    logic [HDR_BITS-1:0] h;
    h[0] = 1'b1;
    h[1] = ap;
    h[2] = rd;
    h[3] = addr[0];
    h[4] = addr[1];
    h[5] = hdr_parity(ap, rd, addr);
    h[6] = 1'b0;
    h[7] = 1'b1;
    return h;
  endfunction

endpackage

// File: rtl/sdbg_clkdiv.sv
module sdbg_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic link_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          half_end;

  assign half_end  = run && (cnt_q == LAST);
  assign rise_tick = half_end && !ph_q;
  assign fall_tick = half_end && ph_q;
  assign link_clk  = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: an idle divider leaves the link clock low
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !link_clk);

  // R2: the clock never rises or falls mid half-period
  p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_end) |=> $stable(link_clk));

endmodule

// File: rtl/sdbg_hdr.sv
module sdbg_hdr
  import sdbg_pkg::*;
(
  input  logic                ap,
  input  logic                rd,
  input  logic [1:0]          addr,
  output logic [HDR_BITS-1:0] hdr
);
  always_comb begin
    hdr = build_hdr(ap, rd, addr);
    // R4: fields plus parity always hold an even count of ones
    p_hdr_even_r4: assert ((hdr[1] + hdr[2] + hdr[3] + hdr[4] + hdr[5]) % 2 == 0);
  end
endmodule

// File: rtl/sdbg_seq.sv
module sdbg_seq
  import sdbg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 rd,
  input  logic [HDR_BITS-1:0]  hdr,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 bit_end,
  input  logic                 din,
  output logic                 busy,
  output logic                 dout,
  output logic                 doe,
  output logic [2:0]           ack,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 perr,
  output logic                 done
);
  seq_state_t           st_q;
  logic [CNT_W-1:0]     bit_q;
  logic [PAY_BITS-1:0]  tx_q;
  logic [PAY_BITS-1:0]  wbuf_q;
  logic [PAY_BITS-1:0]  rx_q;
  logic                 rd_q;

  // named internal events
  logic                 take_cmd;
  logic                 hdr_last;
  logic                 ack_last;
  logic                 pay_last;
  logic [2:0]           ack_next;
  logic [PAY_BITS-1:0]  rx_next;
  logic                 ack_is_ok;
  logic                 rx_par_bad;

  assign busy       = (st_q != ST_IDLE);
  assign take_cmd   = start && !busy;
  assign hdr_last   = (bit_q == CNT_W'(HDR_BITS - 1));
  assign ack_last   = (bit_q == CNT_W'(ACK_BITS - 1));
  assign pay_last   = (bit_q == CNT_W'(PAY_BITS - 1));
  assign ack_next   = {din, ack[2:1]};
  assign rx_next    = {din, rx_q[PAY_BITS-1:1]};
  assign ack_is_ok  = (ack_next == ACK_OK);
  assign rx_par_bad = rx_next[PAY_BITS-1] != word_parity(rx_next[DATA_BITS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      tx_q   <= '0;
      wbuf_q <= '0;
      rx_q   <= '0;
      rd_q   <= 1'b0;
      dout   <= 1'b0;
      doe    <= 1'b1;
      ack    <= '0;
      rdata  <= '0;
      perr   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take_cmd) begin
        st_q   <= ST_HDR;
        bit_q  <= '0;
        tx_q   <= PAY_BITS'(hdr);
        wbuf_q <= {word_parity(wdata), wdata};
        rd_q   <= rd;
        dout   <= hdr[0];
        doe    <= 1'b1;
        ack    <= '0;
        rdata  <= '0;
        perr   <= 1'b0;
      end else if (bit_end) begin
        unique case (st_q)
          ST_HDR: begin
            if (hdr_last) begin
              st_q  <= ST_TRN_H;
              doe   <= 1'b0;
              dout  <= 1'b0;
              bit_q <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= tx_q >> 1;
              dout  <= tx_q[1];
            end
          end
          ST_TRN_H: begin
            st_q  <= ST_ACK;
            bit_q <= '0;
          end
          ST_ACK: begin
            ack <= ack_next;
            if (ack_last) begin
              bit_q <= '0;
              if (!ack_is_ok)  st_q <= ST_TRN_E;
              else if (rd_q)   st_q <= ST_RDAT;
              else             st_q <= ST_TRN_W;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_TRN_W: begin
            st_q  <= ST_WDAT;
            doe   <= 1'b1;
            dout  <= wbuf_q[0];
            tx_q  <= wbuf_q;
            bit_q <= '0;
          end
          ST_WDAT: begin
            if (pay_last) begin
              st_q <= ST_IDLE;
              dout <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= tx_q >> 1;
              dout  <= tx_q[1];
            end
          end
          ST_RDAT: begin
            rx_q <= rx_next;
            if (pay_last) begin
              rdata <= rx_next[DATA_BITS-1:0];
              perr  <= rx_par_bad;
              st_q  <= ST_TRN_E;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
          ST_TRN_E: begin
            st_q <= ST_IDLE;
            doe  <= 1'b1;
            dout <= 1'b0;
            done <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: header bits are always host driven
  p_hdr_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> doe);

  // R5: turnaround bits leave the line released
  p_trn_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRN_H || st_q == ST_TRN_W || st_q == ST_TRN_E) |-> !doe);

  // R6: the acknowledge is received with the line released
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK) |-> !doe);

  // R8: read payload is received with the line released
  p_rdat_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDAT) |-> !doe);

  // R7: write payload is host driven
  p_wdat_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDAT) |-> doe);

  // R10: a refused transaction returns no data
  p_nok_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ack != ACK_OK) |-> (rdata == '0 && !perr));

  // R11: done is a single-cycle strobe
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: a start while busy does not restart the header
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && st_q != ST_HDR) |=> (st_q != ST_HDR));

endmodule

// File: rtl/sdbg_host.sv
module sdbg_host
  import sdbg_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_start,
  input  logic                 cmd_ap,
  input  logic                 cmd_rd,
  input  logic [1:0]           cmd_addr,
  input  logic [DATA_BITS-1:0] cmd_wdata,
  output logic [2:0]           rsp_ack,
  output logic [DATA_BITS-1:0] rsp_rdata,
  output logic                 rsp_perr,
  output logic                 rsp_done,
  output logic                 dbg_clk,
  output logic                 dbg_dout,
  output logic                 dbg_doe,
  input  logic                 dbg_din
);
  logic                busy;
  logic                rise_tick;
  logic                fall_tick;
  logic [HDR_BITS-1:0] hdr_word;

  sdbg_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .link_clk  (dbg_clk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  sdbg_hdr u_hdr (
    .ap   (cmd_ap),
    .rd   (cmd_rd),
    .addr (cmd_addr),
    .hdr  (hdr_word)
  );

  sdbg_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cmd_start),
    .rd      (cmd_rd),
    .hdr     (hdr_word),
    .wdata   (cmd_wdata),
    .bit_end (fall_tick),
    .din     (dbg_din),
    .busy    (busy),
    .dout    (dbg_dout),
    .doe     (dbg_doe),
    .ack     (rsp_ack),
    .rdata   (rsp_rdata),
    .perr    (rsp_perr),
    .done    (rsp_done)
  );

  // R2: host-side line changes happen only while the link clock is low
  p_host_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clk |-> ($stable(dbg_dout) && $stable(dbg_doe)));

  // R1: the done strobe comes with the clock back at idle level
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !dbg_clk);

  // R2: the rise tick never arrives while idle
  p_tick_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> busy);

endmodule

// File: tb/sdbg_host_tb.sv
module sdbg_host_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        cmd_ap = 1'b0;
  logic        cmd_rd = 1'b0;
  logic [1:0]  cmd_addr = 2'b00;
  logic [31:0] cmd_wdata = '0;
  logic [2:0]  rsp_ack;
  logic [31:0] rsp_rdata;
  logic        rsp_perr;
  logic        rsp_done;
  logic        dbg_clk;
  logic        dbg_dout;
  logic        dbg_doe;
  logic        dbg_din = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // target model configuration
  logic [2:0]  t_ack;
  logic        t_rd;
  logic [31:0] t_data;
  logic        t_flip;
  int          edge_n;
  logic        rec_out [64];
  logic        rec_oe  [64];
  int          rise_cyc [64];

  sdbg_host #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ap(cmd_ap),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .rsp_done(rsp_done), .dbg_clk(dbg_clk), .dbg_dout(dbg_dout),
    .dbg_doe(dbg_doe), .dbg_din(dbg_din)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic odd_ones(input logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) if (w[i]) n++;
    return (n % 2) == 1;
  endfunction

  // target: records host bits and drives its own on each rising link clock
  always @(posedge dbg_clk) begin
    if (edge_n < 64) begin
      rec_out[edge_n]  = dbg_dout;
      rec_oe[edge_n]   = dbg_doe;
      rise_cyc[edge_n] = cyc;
    end
    if (edge_n >= 9 && edge_n <= 11)
      dbg_din <= t_ack[edge_n - 9];
    else if (t_rd && t_ack == 3'b001 && edge_n >= 12 && edge_n <= 43)
      dbg_din <= t_data[edge_n - 12];
    else if (t_rd && t_ack == 3'b001 && edge_n == 44)
      dbg_din <= odd_ones(t_data) ^ t_flip;
    else
      dbg_din <= 1'b1;
    edge_n = edge_n + 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic ap, input logic rd, input logic [1:0] addr,
                     input logic [31:0] wdata, input logic [2:0] ack,
                     input logic [31:0] rdat, input logic flip, input logic poke);
    logic [7:0] exp_hdr;
    logic [7:0] got_hdr;
    logic       hoe;
    logic       ok;
    int         n_exp;
    int         waited;
    t_ack = ack; t_rd = rd; t_data = rdat; t_flip = flip;
    edge_n = 0;
    @(negedge clk);
    cmd_ap = ap; cmd_rd = rd; cmd_addr = addr; cmd_wdata = wdata;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    waited = 0;
    while (!rsp_done && waited < 2000) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 40) begin
        cmd_ap = ~ap; cmd_rd = ~rd; cmd_addr = ~addr; cmd_wdata = ~wdata;
        cmd_start = 1'b1;
      end else begin
        cmd_start = 1'b0;
      end
    end
    cmd_start = 1'b0;
    chk(rsp_done, "R11 done seen", {63'd0, rsp_done}, 64'd1);
    // R3 header order, R4 parity
    exp_hdr = {1'b1, 1'b0, 1'b0, addr[1], addr[0], rd, ap, 1'b1};
    exp_hdr[5] = ((int'(ap) + int'(rd) + int'(addr[0]) + int'(addr[1])) % 2) == 1;
    hoe = 1'b1;
    for (int i = 0; i < 8; i++) begin
      got_hdr[i] = rec_out[i];
      hoe = hoe & rec_oe[i];
    end
    chk(got_hdr == exp_hdr && hoe, "R3 header bits", {56'd0, got_hdr}, {56'd0, exp_hdr});
    chk(got_hdr[5] == exp_hdr[5], "R4 header parity", {63'd0, got_hdr[5]}, {63'd0, exp_hdr[5]});
    chk(rec_oe[8] == 1'b0, "R5 turnaround after header", {63'd0, rec_oe[8]}, 64'd0);
    ok = !rec_oe[9] && !rec_oe[10] && !rec_oe[11] && rsp_ack == ack;
    chk(ok, "R6 acknowledge", {61'd0, rsp_ack}, {61'd0, ack});
    n_exp = (ack == 3'b001) ? 46 : 13;
    if (ack != 3'b001) begin
      chk(edge_n == n_exp && !rec_oe[12], "R10 short length",
          64'(edge_n), 64'(n_exp));
      chk(rsp_rdata == '0 && !rsp_perr, "R10 no data",
          {31'd0, rsp_perr, rsp_rdata}, 64'd0);
    end else if (rd) begin
      ok = 1'b1;
      for (int i = 12; i <= 45; i++) ok = ok & !rec_oe[i];
      chk(ok && edge_n == n_exp, "R8 read released and length",
          64'(edge_n), 64'(n_exp));
      chk(rsp_rdata == rdat, "R8 read data", {32'd0, rsp_rdata}, {32'd0, rdat});
      chk(rsp_perr == flip, "R9 parity flag", {63'd0, rsp_perr}, {63'd0, flip});
    end else begin
      logic [32:0] got_w;
      logic [32:0] exp_w;
      exp_w = {odd_ones(wdata), wdata};
      ok = !rec_oe[12] && edge_n == n_exp;
      for (int i = 0; i < 33; i++) begin
        got_w[i] = rec_out[13 + i];
        ok = ok & rec_oe[13 + i];
      end
      chk(ok, "R7 write turnaround and length", 64'(edge_n), 64'(n_exp));
      chk(got_w == exp_w, "R7 write payload", {31'd0, got_w}, {31'd0, exp_w});
    end
    @(negedge clk);
    chk(!rsp_done, "R11 done one cycle", {63'd0, rsp_done}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!dbg_clk && !dbg_dout && dbg_doe, "R1 idle line",
        {61'd0, dbg_clk, dbg_dout, dbg_doe}, 64'd1);
    chk(rsp_ack == ack, "R11 result held", {61'd0, rsp_ack}, {61'd0, ack});
  endtask

  initial begin
    edge_n = 0; t_ack = 3'b001; t_rd = 1'b0; t_data = '0; t_flip = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dbg_clk && !dbg_dout && dbg_doe && !rsp_done, "R1 in reset",
        {60'd0, dbg_clk, dbg_dout, dbg_doe, rsp_done}, 64'd2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!dbg_clk && !dbg_dout && dbg_doe && !rsp_done, "R1 after reset",
        {60'd0, dbg_clk, dbg_dout, dbg_doe, rsp_done}, 64'd2);

    // all header combinations with OK
    for (int c = 0; c < 16; c++) begin
      logic [31:0] w;
      w = 32'hA5C3_0F00 ^ (32'(c) * 32'h0101_0101);
      run(c[0], c[1], c[3:2], w, 3'b001, {w[15:0], ~w[31:16]}, 1'b0, 1'b0);
    end
    // R2 bit period
    chk(rise_cyc[1] - rise_cyc[0] == 2 * HALF, "R2 bit period",
        64'(rise_cyc[1] - rise_cyc[0]), 64'(2 * HALF));

    // walking ones and extremes on both directions
    for (int b = 0; b < 32; b += 7) begin
      run(1'b1, 1'b1, 2'b11, '0, 3'b001, 32'h1 << b, 1'b0, 1'b0);
      run(1'b0, 1'b0, 2'b01, 32'h1 << b, 3'b001, '0, 1'b0, 1'b0);
    end
    run(1'b0, 1'b1, 2'b00, '0, 3'b001, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run(1'b0, 1'b0, 2'b10, 32'hFFFF_FFFF, 3'b001, '0, 1'b0, 1'b0);
    run(1'b1, 1'b1, 2'b10, '0, 3'b001, 32'h0000_0000, 1'b0, 1'b0);

    // refused acknowledges on both directions
    run(1'b0, 1'b1, 2'b00, 32'h1234_5678, 3'b010, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run(1'b1, 1'b0, 2'b01, 32'h1234_5678, 3'b010, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run(1'b0, 1'b1, 2'b01, 32'h1234_5678, 3'b100, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run(1'b1, 1'b0, 2'b11, 32'h1234_5678, 3'b100, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run(1'b1, 1'b1, 2'b10, 32'h1234_5678, 3'b111, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run(1'b0, 1'b0, 2'b00, 32'h1234_5678, 3'b000, 32'hDEAD_BEEF, 1'b0, 1'b0);

    // R9 bad parity still returns data
    run(1'b1, 1'b1, 2'b01, '0, 3'b001, 32'h8001_7FFE, 1'b1, 1'b0);
    run(1'b0, 1'b1, 2'b11, '0, 3'b001, 32'h0000_0007, 1'b1, 1'b0);

    // R11 start while busy is ignored
    run(1'b0, 1'b0, 2'b10, 32'hC0DE_F00D, 3'b001, '0, 1'b0, 1'b1);
    run(1'b1, 1'b1, 2'b01, '0, 3'b001, 32'h5A5A_1234, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule